// File: doc/BRIEF.md
# Half-Full Primed Elastic Buffer

This block carries one serial lane's 10-bit line symbols from the clock recovered from the incoming bit stream into the local core clock. The two clocks may differ in frequency by several hundred ppm, so a plain dual-clock FIFO would slowly fill up or drain. The buffer therefore sits just after the deserializer and before the 8b/10b decoder, and it keeps its fill near the middle of its storage. Symbols are stored undecoded, so a loopback path can return them bit for bit.

Fill correction happens only inside clock-compensation ordered-sets: a comma symbol (COM) followed by skip symbols (SKP). On the read side, a SKP of such a set is sent twice when the buffer is running low. When the buffer is running high, a SKP is skipped. A set gets at most `MAX_EDITS` such edits and always keeps at least one SKP. Any error left over is corrected on later sets. Adding or dropping SKP symbols is the only change the block ever makes to the stream.

Write and read pointers cross between the clock domains in Gray code through two-flop synchronizers. Each domain computes its own fill level from its own pointer and the synchronized pointer of the other side. The write side reports overflow. The read side reports underflow and then waits to prime again.

Top module: `ebuf_primed`

## Requirements
- R1: Every symbol accepted on the write side is delivered on the read side in the same order and with the same value. The only difference allowed in the output stream is added or removed SKP symbols.
- R2: After reset `rdValid`, `rdUnderflow` and `wrOverflow` are low. The reader emits nothing until its own fill level reaches DEPTH/2.
- R3: A write offered while the write-side fill equals DEPTH is discarded, and `wrOverflow` is high for the following write-clock cycle. No entry is ever written into a full buffer.
- R4: If the read-side fill is zero while the reader is running, the read pointer does not move. `rdUnderflow` pulses for exactly one cycle with `rdValid` low, and the reader goes back to priming.
- R5: A set is a COM (0011111010 or 1100000101) followed by SKPs (0011110100 or 1100001011). If the next symbol to emit is a SKP of a set and the read-side fill is below DEPTH/2, that SKP is emitted and then emitted again. The added symbol is an exact copy of the set's SKP code, so running disparity stays correct.
- R6: If the next symbol to emit is a SKP of a set and the read-side fill is above DEPTH/2, that SKP is skipped and the symbol after it is emitted instead. The read pointer then advances by two.
- R7: No set receives more than MAX_EDITS insertions or removals in total (default 2; may be set to 1). The count restarts at every COM.
- R8: Every set leaves the block with at least one SKP. A SKP is removed only when the symbol after it is a SKP, or when a SKP of the same set has already been emitted.
- R9: With a write clock 1% slower than the read clock, the net change in SKP count is an increase. With a write clock 1% faster, it is a decrease. In both cases the buffer neither overflows nor underflows while sets arrive at least every 36 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered receive clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrValid | input | 1 | A symbol is presented on wrSym |
| wrSym | input | 10 | Undecoded symbol from the deserializer |
| wrOverflow | output | 1 | One-cycle pulse: a symbol was dropped because the buffer was full |
| rdClk | input | 1 | Local core clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| rdSym | output | 10 | Symbol delivered to the decoder |
| rdValid | output | 1 | rdSym holds a new symbol this cycle |
| rdUnderflow | output | 1 | One-cycle pulse: the buffer ran empty while reading |

## Verification
The stream is data symbols with a COM plus three SKPs every 36 symbols. It runs first with the write clock 1% slow and then 1% fast. A scoreboard checks every non-SKP symbol against its expected value, so any loss or change of data is caught. Each SKP run is measured, which separates correct SKP insertion from correct SKP removal through the sign of the net change in each phase. Halting the writer exposes the single underflow pulse. After a reset, a write clock running at twice the read rate with no sets forces the overflow path.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int SYM_W = 10;

  localparam logic [SYM_W-1:0] COM_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COM_POS = 10'b1100000101;
  localparam logic [SYM_W-1:0] SKP_NEG = 10'b0011110100;
  localparam logic [SYM_W-1:0] SKP_POS = 10'b1100001011;

  // strobes from control to storage
  typedef struct packed {
    logic push;   // write domain: store wrSym
    logic adv1;   // read domain: consume one entry
    logic adv2;   // read domain: consume two entries (SKP dropped)
  } ebufStrbT;

  function automatic logic isCom(input logic [SYM_W-1:0] s);
    return (s == COM_NEG) || (s == COM_POS);
  endfunction

  function automatic logic isSkp(input logic [SYM_W-1:0] s);
    return (s == SKP_NEG) || (s == SKP_POS);
  endfunction
endpackage

// File: rtl/ebuf_datapath.sv
module ebuf_datapath
  import ebuf_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  ebufStrbT         stb,
  input  logic [SYM_W-1:0] wrSym,
  output logic [PW-1:0]    wrFill,
  output logic [PW-1:0]    rdFill,
  output logic [SYM_W-1:0] headSym,
  output logic [SYM_W-1:0] nextSym
);
  logic [SYM_W-1:0] mem [DEPTH];

  logic [PW-1:0] wrPtr, wrGray, rdPtr, rdGray;
  logic [SYNC_STAGES-1:0][PW-1:0] rdGrayToWr, wrGrayToRd;
  logic [PW-1:0] wrPtrNext, rdPtrNext, rdPtrPlus1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign wrPtrNext = wrPtr + PW'(stb.push);

  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrPtr[AW-1:0]] <= wrSym;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr      <= '0;
      wrGray     <= '0;
      rdGrayToWr <= '0;
    end else begin
      wrPtr      <= wrPtrNext;
      wrGray     <= wrPtrNext ^ (wrPtrNext >> 1);
      rdGrayToWr <= {rdGrayToWr[SYNC_STAGES-2:0], rdGray};
    end
  end

  assign wrFill = wrPtr - gray2bin(rdGrayToWr[SYNC_STAGES-1]);

  // read domain
  always_comb begin
    rdPtrNext = rdPtr;
    if (stb.adv1) rdPtrNext = rdPtr + PW'(1);
    if (stb.adv2) rdPtrNext = rdPtr + PW'(2);
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr      <= '0;
      rdGray     <= '0;
      wrGrayToRd <= '0;
    end else begin
      rdPtr      <= rdPtrNext;
      rdGray     <= rdPtrNext ^ (rdPtrNext >> 1);
      wrGrayToRd <= {wrGrayToRd[SYNC_STAGES-2:0], wrGray};
    end
  end

  assign rdPtrPlus1 = rdPtr + PW'(1);
  assign rdFill     = gray2bin(wrGrayToRd[SYNC_STAGES-1]) - rdPtr;
  assign headSym    = mem[rdPtr[AW-1:0]];
  assign nextSym    = mem[rdPtrPlus1[AW-1:0]];
endmodule

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
  import ebuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_EDITS = 2,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2,
  localparam int CW   = $clog2(MAX_EDITS + 1)
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrValid,
  input  logic [PW-1:0]    wrFill,
  output logic             wrOverflow,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [PW-1:0]    rdFill,
  input  logic [SYM_W-1:0] headSym,
  input  logic [SYM_W-1:0] nextSym,
  output ebufStrbT         stb,
  output logic [SYM_W-1:0] rdSym,
  output logic             rdValid,
  output logic             rdUnderflow
);
  logic wrFull;
  logic running, inSet, lastSkp;
  logic [CW-1:0] editCnt;
  logic rdEmpty, emit, canEdit, doIns, doDel;
  logic [SYM_W-1:0] outSym;

  assign wrFull = (wrFill == PW'(DEPTH));

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) wrOverflow <= 1'b0;
    else         wrOverflow <= wrValid && wrFull;
  end

  always_comb begin
    rdEmpty  = (rdFill == '0);
    emit     = running && !rdEmpty;
    canEdit  = emit && inSet && isSkp(headSym) && (editCnt < CW'(MAX_EDITS));
    doIns    = canEdit && (rdFill < PW'(HALF));
    doDel    = canEdit && (rdFill > PW'(HALF)) && (isSkp(nextSym) || lastSkp);
    outSym   = doDel ? nextSym : headSym;
    stb.push = wrValid && !wrFull;
    stb.adv1 = emit && !doIns && !doDel;
    stb.adv2 = doDel;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      running     <= 1'b0;
      inSet       <= 1'b0;
      lastSkp     <= 1'b0;
      editCnt     <= '0;
      rdSym       <= '0;
      rdValid     <= 1'b0;
      rdUnderflow <= 1'b0;
    end else begin
      rdValid     <= emit;
      rdUnderflow <= running && rdEmpty;
      if (!running)     running <= (rdFill >= PW'(HALF));
      else if (rdEmpty) running <= 1'b0;
      if (emit) begin
        rdSym   <= outSym;
        inSet   <= isCom(outSym) || (inSet && isSkp(outSym));
        lastSkp <= inSet && isSkp(outSym);
        if (isCom(outSym))      editCnt <= '0;
        else if (doIns || doDel) editCnt <= editCnt + CW'(1);
      end else if (running && rdEmpty) begin
        inSet   <= 1'b0;
        lastSkp <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ebuf_primed.sv
module ebuf_primed
  import ebuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_EDITS = 2,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrValid,
  input  logic [SYM_W-1:0] wrSym,
  output logic             wrOverflow,
  input  logic             rdClk,
  input  logic             rdRstN,
  output logic [SYM_W-1:0] rdSym,
  output logic             rdValid,
  output logic             rdUnderflow
);
  ebufStrbT         stb;
  logic [PW-1:0]    wrFill, rdFill;
  logic [SYM_W-1:0] headSym, nextSym;

  ebuf_datapath #(.DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .stb(stb), .wrSym(wrSym), .wrFill(wrFill), .rdFill(rdFill),
    .headSym(headSym), .nextSym(nextSym)
  );

  ebuf_ctrl #(.DEPTH(DEPTH), .MAX_EDITS(MAX_EDITS)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrFill(wrFill),
    .wrOverflow(wrOverflow), .rdClk(rdClk), .rdRstN(rdRstN), .rdFill(rdFill),
    .headSym(headSym), .nextSym(nextSym), .stb(stb), .rdSym(rdSym),
    .rdValid(rdValid), .rdUnderflow(rdUnderflow)
  );
endmodule

// File: rtl/ebuf_primed_chk.sv
module ebuf_primed_chk
  import ebuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_EDITS = 2,
  parameter int SET_SKPS  = 3,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input logic             wrClk,
  input logic             wrRstN,
  input logic             rdClk,
  input logic             rdRstN,
  input ebufStrbT         stb,
  input logic [PW-1:0]    wrFill,
  input logic [PW-1:0]    rdFill,
  input logic [SYM_W-1:0] rdSym,
  input logic             rdValid,
  input logic             rdUnderflow,
  input logic             wrOverflow
);
  int skpRun;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) skpRun <= 0;
    else if (rdValid) begin
      if (isSkp(rdSym)) skpRun <= skpRun + 1;
      else              skpRun <= 0;
    end
  end

  assert_no_push_when_full_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    stb.push |-> (wrFill < PW'(DEPTH)));

  assert_overflow_drops_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrOverflow |-> !$past(stb.push));

  assert_underflow_quiet_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdUnderflow |-> !rdValid);

  assert_no_advance_empty_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdFill == '0) |-> !(stb.adv1 || stb.adv2));

  assert_drop_above_half_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    stb.adv2 |-> (rdFill > PW'(HALF)));

  assert_single_step_R1: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $onehot0({stb.adv1, stb.adv2}));

  assert_edit_cap_R7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && isSkp(rdSym)) |-> (skpRun < SET_SKPS + MAX_EDITS));

  assert_set_keeps_skp_R8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    ($past(rdValid && isCom(rdSym)) && rdValid) |-> isSkp(rdSym));
endmodule

bind ebuf_primed ebuf_primed_chk #(.DEPTH(DEPTH), .MAX_EDITS(MAX_EDITS)) u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN), .stb(stb),
  .wrFill(wrFill), .rdFill(rdFill), .rdSym(rdSym), .rdValid(rdValid),
  .rdUnderflow(rdUnderflow), .wrOverflow(wrOverflow)
);

// File: tb/ebuf_primed_tb.sv
`timescale 1ns/1ps
module ebuf_primed_tb;
  localparam int HALF = 8;
  localparam int CAP  = 2;
  localparam logic [9:0] C_A = 10'b0011111010, C_B = 10'b1100000101;
  localparam logic [9:0] S_A = 10'b0011110100, S_B = 10'b1100001011;

  typedef struct { logic [9:0] sym; logic [9:0] skp; int phase; } expT;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0, wrValid = 0;
  logic [9:0] wrSym = '0;
  logic [9:0] rdSym;
  logic rdValid, rdUnderflow, wrOverflow;
  real wrHalf = 4.04;

  always #4 rdClk = ~rdClk;
  always #(wrHalf) wrClk = ~wrClk;

  ebuf_primed u_dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrSym(wrSym),
    .wrOverflow(wrOverflow), .rdClk(rdClk), .rdRstN(rdRstN), .rdSym(rdSym),
    .rdValid(rdValid), .rdUnderflow(rdUnderflow)
  );

  expT q[$];
  int checks = 0, fails = 0, wrCount = 0, ufCount = 0, ovfCount = 0;
  int delta[2] = '{0, 0};
  bit sbOn = 0, firstSeen = 0, inRun = 0;
  int runLen = 0, runPhase = 0;
  logic [9:0] runSkp = '0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [9:0] dataSym();
    logic [9:0] s;
    do s = 10'($urandom); while (s == C_A || s == C_B || s == S_A || s == S_B);
    return s;
  endfunction

  task automatic sendSym(input logic [9:0] s);
    @(negedge wrClk);
    wrValid = 1; wrSym = s; wrCount++;
  endtask

  task automatic sendStream(input int nSets, input int phase);
    for (int k = 0; k < nSets; k++) begin
      bit pol = 1'($urandom);
      logic [9:0] c = pol ? C_B : C_A;
      logic [9:0] sk = pol ? S_B : S_A;
      for (int d = 0; d < 32; d++) begin
        logic [9:0] s = dataSym();
        q.push_back('{s, 10'd0, phase});
        sendSym(s);
      end
      q.push_back('{c, sk, phase});
      sendSym(c);
      for (int j = 0; j < 3; j++) sendSym(sk);
    end
    for (int d = 0; d < 8; d++) begin
      logic [9:0] s = dataSym();
      q.push_back('{s, 10'd0, phase});
      sendSym(s);
    end
  endtask

  task automatic handle(input logic [9:0] s);
    expT e;
    if (inRun && (s == S_A || s == S_B)) begin
      chk(s == runSkp, $sformatf("R5 SKP copy %b expected %b", s, runSkp));
      runLen++;
    end else begin
      if (inRun) begin
        chk(runLen >= 1, $sformatf("R8 SKP run %0d expected >= 1", runLen));
        chk(runLen >= 3 - CAP && runLen <= 3 + CAP,
            $sformatf("R7 SKP run %0d expected %0d..%0d", runLen, 3 - CAP, 3 + CAP));
        delta[runPhase] += runLen - 3;
        inRun = 0;
      end
      if (q.size() == 0) chk(0, $sformatf("R1 got %b expected nothing", s));
      else begin
        e = q.pop_front();
        chk(s == e.sym, $sformatf("R1 got %b expected %b", s, e.sym));
        if (e.sym == C_A || e.sym == C_B) begin
          inRun = 1; runLen = 0; runSkp = e.skp; runPhase = e.phase;
        end
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge rdClk) begin
    if (sbOn) begin
      if (rdUnderflow) ufCount++;
      if (rdValid) begin
        if (!firstSeen) begin
          firstSeen = 1;
          chk(wrCount >= HALF, $sformatf("R2 output after %0d writes expected >= %0d", wrCount, HALF));
        end
        handle(rdSym);
      end
    end
  end

  always @(negedge wrClk) if (wrOverflow) ovfCount++;

  task automatic checkReset();
    chk(rdValid == 0, $sformatf("R2 rdValid %b expected 0", rdValid));
    chk(rdUnderflow == 0, $sformatf("R2 rdUnderflow %b expected 0", rdUnderflow));
    chk(wrOverflow == 0, $sformatf("R2 wrOverflow %b expected 0", wrOverflow));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge rdClk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge rdClk);
    checkReset();
    wrRstN = 1; rdRstN = 1; sbOn = 1;
    // R9 / R5: write clock 1% slow -> insertions
    sendStream(80, 0);
    // R9 / R6: write clock 1% fast -> removals
    wrHalf = 3.96;
    sendStream(80, 1);
    @(negedge wrClk) wrValid = 0;
    repeat (200) @(negedge rdClk);
    chk(q.size() == 0, $sformatf("R1 undelivered %0d expected 0", q.size()));
    chk(ufCount == 1, $sformatf("R4 underflow pulses %0d expected 1", ufCount));
    chk(rdValid == 0, $sformatf("R4 rdValid %b expected 0", rdValid));
    chk(ovfCount == 0, $sformatf("R9 overflow pulses %0d expected 0", ovfCount));
    chk(delta[0] > 0, $sformatf("R9 slow-write SKP net %0d expected > 0", delta[0]));
    chk(delta[1] < 0, $sformatf("R9 fast-write SKP net %0d expected < 0", delta[1]));
    // R3: overflow with write rate doubled and no sets
    sbOn = 0;
    wrRstN = 0; rdRstN = 0;
    repeat (3) @(negedge rdClk);
    checkReset();
    wrRstN = 1; rdRstN = 1; ovfCount = 0;
    wrHalf = 2.0;
    for (int i = 0; i < 100; i++) sendSym(dataSym());
    @(negedge wrClk) wrValid = 0;
    repeat (4) @(negedge wrClk);
    chk(ovfCount > 0, $sformatf("R3 overflow pulses %0d expected > 0", ovfCount));
    summary();
  end
endmodule